// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a shared memory and lets two agents signal each other. Each of the two ports owns four 16-bit mailbox words. A port writes its own mailboxes and can read them back. When a write includes the upper byte of a mailbox, an interrupt for that mailbox becomes pending at the other port. The receiving port reads the sender's mailbox through a separate address window. A read of the upper byte there acknowledges the interrupt and leaves the stored word unchanged.

Each port has a control word. It holds that port's four mask bits and two views of its interrupts, both active low. The status view shows every pending source, masked or not. The cause view shows only the sources that were unmasked when they were raised. The port's interrupt pin is active low and is asserted while any pending source is unmasked.

Both ports use a synchronous bus. Its signals are an active-low select, a write-low/read-high strobe, active-low upper and lower byte enables, a 6-bit address and 16-bit write data. Read data is registered and appears one cycle after the read.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: With select low and the strobe low at address 6'b1000_ii (ii = mailbox index), a port writes its own mailbox ii. The lower byte enable writes bits 7:0 and the upper byte enable writes bits 15:8. A read at the same address returns the full stored word on the next cycle.
- R2: A write to a port's own mailbox with the upper byte enable low makes the interrupt for that mailbox pending at the opposite port. A write that enables only the lower byte raises nothing.
- R3: Reading back a port's own mailbox does not change the interrupt pending at the opposite port.
- R4: A read at address 6'b1001_ii returns the opposite port's mailbox ii. If the upper byte enable is low and the select has just fallen, the read clears the pending and cause bits for mailbox ii at the reading port. The stored word is not changed.
- R5: An upper-byte read of the opposite mailbox clears nothing when the select was already low in the previous cycle.
- R6: The control word is at address 6'b1010_00. On read, bits 3:0 are the mask, bits 7:4 are the inverted cause bits and bits 11:8 are the inverted status bits. Bit n of each field belongs to mailbox n. A write with the lower byte enable low loads all four mask bits from write-data bits 3:0. Each port can change only its own mask.
- R7: A source raised while its mask bit is 1 sets its status bit but not its cause bit. Unmasking it later does not set its cause bit either.
- R8: The interrupt output of a port is low exactly when some pending source of that port has a mask bit of 0.
- R9: If a raise and a clear for the same mailbox of a port happen in the same cycle, the source stays pending.
- R10: Writes to reserved addresses, such as 6'b0000_00 and 6'b1111_11, change no mailbox, mask or pending state.
- R11: While reset is low at a clock edge, all pending and cause bits are cleared, all masks are set to 1, read data is cleared to zero and both interrupt outputs go high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sel_n | input | 1 | Port A mailbox select, active low |
| a_wr_n | input | 1 | Port A strobe: 0 write, 1 read |
| a_ub_n | input | 1 | Port A upper byte enable, active low |
| a_lb_n | input | 1 | Port A lower byte enable, active low |
| a_addr | input | 6 | Port A register address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, registered |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_sel_n | input | 1 | Port B mailbox select, active low |
| b_wr_n | input | 1 | Port B strobe: 0 write, 1 read |
| b_ub_n | input | 1 | Port B upper byte enable, active low |
| b_lb_n | input | 1 | Port B lower byte enable, active low |
| b_addr | input | 6 | Port B register address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, registered |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The assertions assume that every bus field of a port holds a known value in any cycle where its select is low. They also assume that the select is high for at least one cycle after reset before the first acknowledging read, so that the falling-edge check sees a real transition. The stimulus meets both conditions: every bus field is always driven to a defined value, and the select rests high between most accesses. A few directed cases deliberately hold the select low across back-to-back accesses to exercise the case where no edge occurs. Reserved addresses are only written, or read without checking the result, because their read data is undefined.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int N_MBOX = 4;
   localparam logic [3:0] OWN_WIN  = 4'b1000;
   localparam logic [3:0] PEER_WIN = 4'b1001;
   localparam logic [5:0] CTRL_ADR = 6'b101000;

   typedef enum logic [1:0] {ACC_RSVD, ACC_OWN, ACC_PEER, ACC_CTRL} acc_e;

   function automatic acc_e decode(input logic [5:0] a);
      if (a[5:2] == OWN_WIN)       return ACC_OWN;
      else if (a[5:2] == PEER_WIN) return ACC_PEER;
      else if (a == CTRL_ADR)      return ACC_CTRL;
      else                         return ACC_RSVD;
   endfunction
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
   parameter int DATA_W = 16,
   parameter int N      = 4,
   localparam int IW    = $clog2(N),
   localparam int LANES = DATA_W / 8
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [IW-1:0]               idx,
   input  logic [LANES-1:0]            lane_we,
   input  logic [DATA_W-1:0]           wdata,
   output logic [N-1:0][DATA_W-1:0]    box_q
);
   for (genvar m = 0; m < N; m++) begin : g_box
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         for (int l = 0; l < LANES; l++) begin
            if (wr_en && idx == IW'(m) && lane_we[l])
               word_q[l*8 +: 8] <= wdata[l*8 +: 8];
         end
      end
      assign box_q[m] = word_q;
   end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_i,
   input  logic [N-1:0] raise_i,
   input  logic [N-1:0] ack_i,
   input  logic [N-1:0] mask_i,
   output logic [N-1:0] pend_q,
   output logic [N-1:0] cause_q
);
   // raise wins over a same-cycle acknowledge
   always_ff @(posedge clk) begin
      if (rst_i) begin
         pend_q  <= '0;
         cause_q <= '0;
      end else begin
         pend_q  <= (pend_q & ~ack_i) | raise_i;
         cause_q <= (cause_q & ~ack_i) | (raise_i & ~mask_i);
      end
   end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
   import mbox_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int N      = 4,
   localparam int IW    = $clog2(N)
) (
   input  logic                     clk,
   input  logic                     rst_i,
   input  logic                     sel_n,
   input  logic                     wr_n,
   input  logic                     ub_n,
   input  logic                     lb_n,
   input  logic [5:0]               addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [N-1:0][DATA_W-1:0] peer_box,
   input  logic [N-1:0]             pend_i,
   input  logic [N-1:0]             cause_i,
   output logic [N-1:0][DATA_W-1:0] box_o,
   output logic [N-1:0]             raise_o,
   output logic [N-1:0]             ack_o,
   output logic [N-1:0]             mask_o,
   output logic [DATA_W-1:0]        rdata,
   output logic                     irq_n
);
   acc_e              acc;
   logic [IW-1:0]     idx;
   logic              wr_hit, rd_hit, sel_q, fall;
   logic              own_wr;
   logic [DATA_W-1:0] rd_val;

   assign acc    = decode(addr);
   assign idx    = addr[IW-1:0];
   assign wr_hit = !sel_n && !wr_n;
   assign rd_hit = !sel_n && wr_n;
   assign fall   = sel_q && !sel_n;
   assign own_wr = wr_hit && (acc == ACC_OWN);

   mbox_store #(.DATA_W(DATA_W), .N(N)) u_store (
      .clk     (clk),
      .wr_en   (own_wr),
      .idx     (idx),
      .lane_we ({!ub_n, !lb_n}),
      .wdata   (wdata),
      .box_q   (box_o)
   );

   always_comb begin
      raise_o = '0;
      ack_o   = '0;
      if (own_wr && !ub_n) raise_o[idx] = 1'b1;
      if (rd_hit && fall && !ub_n && acc == ACC_PEER) ack_o[idx] = 1'b1;
   end

   always_comb begin
      rd_val = '0;
      case (acc)
         ACC_OWN:  rd_val = box_o[idx];
         ACC_PEER: rd_val = peer_box[idx];
         ACC_CTRL: begin
            rd_val[N-1:0]     = mask_o;
            rd_val[2*N-1:N]   = ~cause_i;
            rd_val[3*N-1:2*N] = ~pend_i;
         end
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst_i) begin
         sel_q  <= 1'b1;
         mask_o <= '1;
         rdata  <= '0;
      end else begin
         sel_q <= sel_n;
         if (wr_hit && acc == ACC_CTRL && !lb_n) mask_o <= wdata[N-1:0];
         if (rd_hit) rdata <= rd_val;
      end
   end

   assign irq_n = ~|(pend_i & ~mask_o);
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
   import mbox_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 6,
   parameter bit USE_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_sel_n,
   input  logic              a_wr_n,
   input  logic              a_ub_n,
   input  logic              a_lb_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_irq_n,
   input  logic              b_sel_n,
   input  logic              b_wr_n,
   input  logic              b_ub_n,
   input  logic              b_lb_n,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_irq_n
);
   localparam int N = N_MBOX;

   if (DATA_W != 16) begin : g_bad_width
      $error("mbox_irq_ctrl: DATA_W must be 16 (two byte lanes)");
   end
   if (ADDR_W != 6) begin : g_bad_addr
      $error("mbox_irq_ctrl: ADDR_W must be 6");
   end
   if (3 * N > DATA_W) begin : g_bad_ctrl
      $error("mbox_irq_ctrl: control word cannot hold three fields");
   end

   logic rst_i;
   if (USE_RESET) begin : g_rst
      assign rst_i = !rst_n;
   end else begin : g_norst
      assign rst_i = 1'b0;
   end

   logic [1:0]                     sel_w, wr_w, ub_w, lb_w, irq_w;
   logic [1:0][ADDR_W-1:0]         addr_w;
   logic [1:0][DATA_W-1:0]         wd_w, rd_w;
   logic [1:0][N-1:0][DATA_W-1:0]  box_w;
   logic [1:0][N-1:0]              raise_w, clr_w, pend_w, cause_w, mask_w;

   assign sel_w  = {b_sel_n, a_sel_n};
   assign wr_w   = {b_wr_n,  a_wr_n};
   assign ub_w   = {b_ub_n,  a_ub_n};
   assign lb_w   = {b_lb_n,  a_lb_n};
   assign addr_w = {b_addr,  a_addr};
   assign wd_w   = {b_wdata, a_wdata};
   assign a_rdata = rd_w[0];
   assign b_rdata = rd_w[1];
   assign a_irq_n = irq_w[0];
   assign b_irq_n = irq_w[1];

   for (genvar p = 0; p < 2; p++) begin : g_side
      mbox_port #(.DATA_W(DATA_W), .N(N)) u_port (
         .clk      (clk),
         .rst_i    (rst_i),
         .sel_n    (sel_w[p]),
         .wr_n     (wr_w[p]),
         .ub_n     (ub_w[p]),
         .lb_n     (lb_w[p]),
         .addr     (addr_w[p]),
         .wdata    (wd_w[p]),
         .peer_box (box_w[1-p]),
         .pend_i   (pend_w[p]),
         .cause_i  (cause_w[p]),
         .box_o    (box_w[p]),
         .raise_o  (raise_w[p]),
         .ack_o    (clr_w[p]),
         .mask_o   (mask_w[p]),
         .rdata    (rd_w[p]),
         .irq_n    (irq_w[p])
      );

      mbox_flags #(.N(N)) u_flags (
         .clk     (clk),
         .rst_i   (rst_i),
         .raise_i (raise_w[1-p]),
         .ack_i   (clr_w[p]),
         .mask_i  (mask_w[p]),
         .pend_q  (pend_w[p]),
         .cause_q (cause_w[p])
      );
   end
endmodule

// File: rtl/mbox_irq_ctrl_chk.sv
module mbox_irq_ctrl_chk #(
   parameter int N = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                a_sel_n,
   input logic                a_wr_n,
   input logic                a_ub_n,
   input logic [5:0]          a_addr,
   input logic                b_sel_n,
   input logic                b_irq_n,
   input logic [1:0][N-1:0]   raise_w,
   input logic [1:0][N-1:0]   clr_w,
   input logic [1:0][N-1:0]   pend_w,
   input logic [1:0][N-1:0]   cause_w,
   input logic [1:0][N-1:0]   mask_w
);
   p_raise_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_sel_n && !a_wr_n && !a_ub_n && a_addr[5:2] == 4'b1000)
      |=> pend_w[1][$past(a_addr[1:0])]);

   p_lower_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_sel_n && !a_wr_n && a_ub_n) |-> (raise_w[0] == '0));

   p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_w[0] & ~raise_w[1]) != '0)
      |=> ((pend_w[0] & $past(clr_w[0] & ~raise_w[1])) == '0));

   p_ack_on_fall_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w[0] != '0) |-> $past(a_sel_n));

   p_ack_on_fall_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w[1] != '0) |-> $past(b_sel_n));

   p_cause_in_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_w[0] & ~pend_w[0]) == '0) && ((cause_w[1] & ~pend_w[1]) == '0));

   p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_w[1] == '1) |-> b_irq_n);

   p_raise_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_w[1] != '0)
      |=> ((pend_w[0] & $past(raise_w[1])) == $past(raise_w[1])));

   p_rsvd_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_sel_n && !a_wr_n && a_addr[5:4] != 2'b10)
      |=> (mask_w[0] == $past(mask_w[0])));
endmodule

bind mbox_irq_ctrl mbox_irq_ctrl_chk #(.N(N)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .a_sel_n (a_sel_n),
   .a_wr_n  (a_wr_n),
   .a_ub_n  (a_ub_n),
   .a_addr  (a_addr),
   .b_sel_n (b_sel_n),
   .b_irq_n (b_irq_n),
   .raise_w (raise_w),
   .clr_w   (clr_w),
   .pend_w  (pend_w),
   .cause_w (cause_w),
   .mask_w  (mask_w)
);

// File: tb/mbox_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbox_irq_ctrl_tb_top;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        sel_n [2];
   logic        wr_n  [2];
   logic        ub_n  [2];
   logic        lb_n  [2];
   logic [5:0]  addr  [2];
   logic [15:0] wd    [2];
   logic [15:0] rd    [2];
   logic        irq_n [2];

   int checks = 0;
   int errors = 0;

   logic [15:0] m_box  [2][4];
   logic [3:0]  m_pend [2];
   logic [3:0]  m_cause[2];
   logic [3:0]  m_mask [2];
   logic        m_selq [2];

   mbox_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_sel_n(sel_n[0]), .a_wr_n(wr_n[0]), .a_ub_n(ub_n[0]), .a_lb_n(lb_n[0]),
      .a_addr(addr[0]), .a_wdata(wd[0]), .a_rdata(rd[0]), .a_irq_n(irq_n[0]),
      .b_sel_n(sel_n[1]), .b_wr_n(wr_n[1]), .b_ub_n(ub_n[1]), .b_lb_n(lb_n[1]),
      .b_addr(addr[1]), .b_wdata(wd[1]), .b_rdata(rd[1]), .b_irq_n(irq_n[1])
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input int p, input logic s, input logic w, input logic u,
                        input logic l, input logic [5:0] a, input logic [15:0] d);
      sel_n[p] = s; wr_n[p] = w; ub_n[p] = u; lb_n[p] = l; addr[p] = a; wd[p] = d;
   endtask

   task automatic park(input int p);
      drive(p, 1'b1, 1'b1, 1'b1, 1'b1, 6'h00, 16'h0000);
   endtask

   // one bus cycle for both ports; model predicts, then outputs are compared
   task automatic step();
      logic [3:0]  raise [2];
      logic [3:0]  clr   [2];
      logic [3:0]  nmask [2];
      logic [15:0] er    [2];
      bit          do_rd [2];
      string       tag   [2];
      for (int p = 0; p < 2; p++) begin
         int o = 1 - p;
         int i = int'(addr[p][1:0]);
         raise[p] = 4'h0; clr[p] = 4'h0; nmask[p] = m_mask[p];
         do_rd[p] = 1'b0; er[p] = 16'h0; tag[p] = "";
         if (!sel_n[p] && wr_n[p]) begin
            if (addr[p][5:2] == 4'b1000) begin
               do_rd[p] = 1'b1; er[p] = m_box[p][i]; tag[p] = "R1";
            end else if (addr[p][5:2] == 4'b1001) begin
               do_rd[p] = 1'b1; er[p] = m_box[o][i]; tag[p] = "R4";
               if (!ub_n[p] && m_selq[p]) clr[p][i] = 1'b1;
            end else if (addr[p] == 6'b101000) begin
               do_rd[p] = 1'b1; tag[p] = "R6";
               er[p] = {4'h0, ~m_pend[p], ~m_cause[p], m_mask[p]};
            end
         end
      end
      for (int p = 0; p < 2; p++) begin
         int i = int'(addr[p][1:0]);
         if (!sel_n[p] && !wr_n[p]) begin
            if (addr[p][5:2] == 4'b1000) begin
               if (!lb_n[p]) m_box[p][i][7:0]  = wd[p][7:0];
               if (!ub_n[p]) begin
                  m_box[p][i][15:8] = wd[p][15:8];
                  raise[p][i] = 1'b1;
               end
            end else if (addr[p] == 6'b101000 && !lb_n[p]) begin
               nmask[p] = wd[p][3:0];
            end
         end
      end
      @(posedge clk);
      for (int p = 0; p < 2; p++) begin
         int o = 1 - p;
         m_pend[p]  = (m_pend[p]  & ~clr[p]) | raise[o];
         m_cause[p] = (m_cause[p] & ~clr[p]) | (raise[o] & ~m_mask[p]);
         m_mask[p]  = nmask[p];
         m_selq[p]  = sel_n[p];
      end
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         if (do_rd[p]) begin
            if (tag[p] == "R6") chk("R6", {4'h0, rd[p][11:0]}, {4'h0, er[p][11:0]});
            else                chk(tag[p], rd[p], er[p]);
         end
         chk("R8", {15'h0, irq_n[p]}, {15'h0, ~|(m_pend[p] & ~m_mask[p])});
      end
   endtask

   task automatic idle();
      park(0); park(1); step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      park(0); park(1);
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int p = 0; p < 2; p++) begin
         m_pend[p] = 4'h0; m_cause[p] = 4'h0; m_mask[p] = 4'hF; m_selq[p] = 1'b1;
      end
      // R11 reset state
      chk("R11", {15'h0, irq_n[0]}, 16'h1);
      chk("R11", {15'h0, irq_n[1]}, 16'h1);
      chk("R11", rd[0], 16'h0);
      chk("R11", rd[1], 16'h0);
      drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 6'b101000, 16'h0); park(1); step();
      chk("R11", {4'h0, rd[0][11:0]}, 16'h0FFF);
      idle();

      // enable all sources on both ports
      drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b101000, 16'h0000);
      drive(1, 1'b0, 1'b0, 1'b0, 1'b0, 6'b101000, 16'h0000); step(); idle();

      // fill every mailbox, then acknowledge all of them (R1, R2, R4)
      for (int i = 0; i < 4; i++) begin
         drive(0, 1'b0, 1'b0, 1'b0, 1'b0, {4'b1000, 2'(i)}, 16'hA000 + 16'(i));
         drive(1, 1'b0, 1'b0, 1'b0, 1'b0, {4'b1000, 2'(i)}, 16'hB100 + 16'(i));
         step(); idle();
      end
      chk("R2", {15'h0, irq_n[0]}, 16'h0);
      chk("R2", {15'h0, irq_n[1]}, 16'h0);
      for (int i = 0; i < 4; i++) begin
         drive(0, 1'b0, 1'b1, 1'b0, 1'b0, {4'b1001, 2'(i)}, 16'h0);
         drive(1, 1'b0, 1'b1, 1'b0, 1'b0, {4'b1001, 2'(i)}, 16'h0);
         step(); idle();
      end
      chk("R4", {15'h0, irq_n[0]}, 16'h1);
      chk("R4", {15'h0, irq_n[1]}, 16'h1);

      // R1 / R2: lower-byte-only write merges and raises nothing
      drive(0, 1'b0, 1'b0, 1'b1, 1'b0, 6'b100010, 16'h55CD); park(1); step(); idle();
      chk("R2", {15'h0, irq_n[1]}, 16'h1);
      drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 6'b100010, 16'h0); park(1); step();
      chk("R1", rd[0], 16'hA0CD);
      idle();

      // R3: own readback leaves the peer interrupt pending
      drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b100001, 16'h1234); park(1); step(); idle();
      drive(0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b100001, 16'h0); park(1); step(); idle();
      chk("R3", {15'h0, irq_n[1]}, 16'h0);

      // R5: select held low, no falling edge, no clear
      park(0); drive(1, 1'b0, 1'b1, 1'b1, 1'b1, 6'b000000, 16'h0); step();
      drive(1, 1'b0, 1'b1, 1'b0, 1'b0, 6'b100101, 16'h0); step();
      chk("R5", {15'h0, irq_n[1]}, 16'h0);
      idle();
      drive(1, 1'b0, 1'b1, 1'b0, 1'b0, 6'b100101, 16'h0); step(); idle();
      chk("R4", {15'h0, irq_n[1]}, 16'h1);
      drive(1, 1'b0, 1'b1, 1'b0, 1'b0, 6'b100101, 16'h0); step();
      chk("R4", rd[1], 16'h1234);
      idle();

      // R7: masked source sets status only
      park(0); drive(1, 1'b0, 1'b0, 1'b1, 1'b0, 6'b101000, 16'h0002); step(); idle();
      drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b100001, 16'h7788); park(1); step(); idle();
      chk("R8", {15'h0, irq_n[1]}, 16'h1);
      park(0); drive(1, 1'b0, 1'b1, 1'b1, 1'b1, 6'b101000, 16'h0); step();
      chk("R7", {12'h0, rd[1][7:4]}, 16'h000F);
      chk("R7", {12'h0, rd[1][11:8]}, 16'h000D);
      idle();
      park(0); drive(1, 1'b0, 1'b0, 1'b1, 1'b0, 6'b101000, 16'h0000); step(); idle();
      chk("R8", {15'h0, irq_n[1]}, 16'h0);
      park(0); drive(1, 1'b0, 1'b1, 1'b1, 1'b1, 6'b101000, 16'h0); step();
      chk("R7", {12'h0, rd[1][7:4]}, 16'h000F);
      idle();
      park(0); drive(1, 1'b0, 1'b1, 1'b0, 1'b1, 6'b100101, 16'h0); step(); idle();

      // R9: raise and acknowledge in the same cycle
      drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b100011, 16'h9900); park(1); step(); idle();
      drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b100011, 16'h9911);
      drive(1, 1'b0, 1'b1, 1'b0, 1'b0, 6'b100111, 16'h0); step(); idle();
      chk("R9", {15'h0, irq_n[1]}, 16'h0);
      park(0); drive(1, 1'b0, 1'b1, 1'b0, 1'b0, 6'b100111, 16'h0); step(); idle();

      // R10: reserved writes change nothing; R6: own mask only
      drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000, 16'hFFFF); park(1); step(); idle();
      drive(0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b111111, 16'hFFFF); park(1); step(); idle();
      drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 6'b101000, 16'h0); park(1); step();
      chk("R10", {12'h0, rd[0][3:0]}, 16'h0000);
      chk("R10", {15'h0, irq_n[0]}, 16'h1);
      idle();
      drive(0, 1'b0, 1'b0, 1'b1, 1'b0, 6'b101000, 16'h000F); park(1); step(); idle();
      park(0); drive(1, 1'b0, 1'b1, 1'b1, 1'b1, 6'b101000, 16'h0); step();
      chk("R6", {12'h0, rd[1][3:0]}, 16'h0000);
      idle();

      // constrained random traffic on both ports
      for (int n = 0; n < 3000; n++) begin
         for (int p = 0; p < 2; p++) begin
            logic [1:0] ix = 2'($urandom_range(3));
            logic u = 1'($urandom_range(1));
            logic l = 1'($urandom_range(1));
            logic [15:0] d = 16'($urandom);
            case ($urandom_range(7))
               0, 1: drive(p, 1'b0, 1'b0, u, l, {4'b1000, ix}, d);
               2:    drive(p, 1'b0, 1'b1, u, l, {4'b1000, ix}, d);
               3:    drive(p, 1'b0, 1'b1, u, l, {4'b1001, ix}, d);
               4:    drive(p, 1'b0, 1'b0, u, 1'b0, 6'b101000, d);
               5:    drive(p, 1'b0, 1'b1, u, l, 6'b101000, d);
               6:    drive(p, 1'b0, 1'b0, u, l, (ix[0] ? 6'b111111 : 6'b010100), d);
               default: park(p);
            endcase
         end
         step();
         if ($urandom_range(3) != 0) idle();
      end
      idle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule